// File: doc/BRIEF.md
# Millisecond Delay Timer

This block produces waits measured in whole milliseconds for a power-up and command sequencer. A free prescaler divides the system clock (100 MHz by default) down to a 1 kHz tick, and a millisecond counter advances on every tick until it equals the requested count. The timer then raises its finish flag.

The caller drives a millisecond count and raises an active-high enable. The timer copies the count when it starts and restarts both of its counters from zero. It runs until the count is reached and then holds its finish flag high for as long as enable stays high. Once enable has been seen low, the timer drops the flag and returns to idle, ready for the next request. This handshake matches the serial-link controllers the sequencer already drives. Timing finer than one millisecond is handled elsewhere.

Top module: `ms_delay_timer`

## Requirements
- R1: One millisecond tick occurs every CLK_HZ/TICK_HZ clock cycles (100000 by default), so each extra requested millisecond adds exactly that many cycles to the wait.
- R2: After reset, and while enable stays low in idle, done_o is 0.
- R3: For a request of N, done_o first reads 1 exactly N*(CLK_HZ/TICK_HZ)+1 cycles after the clock edge that first samples en_i high in idle.
- R4: A request of zero raises done_o one cycle after the starting edge.
- R5: done_o stays 1 for as long as en_i remains high after completion.
- R6: done_o stays 1 until the first edge that samples en_i low after completion, and reads 0 immediately after that edge.
- R7: The request is captured at the starting edge, and changes to delay_ms_i while the timer is counting do not change the completion time.
- R8: Both counters restart from zero at every start, so the wait is exact whatever the idle time before it, including back-to-back requests.
- R9: Dropping en_i while the timer is counting does not abort the wait: done_o still rises at the R3 time and then falls one cycle later.
- R10: The full 12-bit request of 4095 completes at the R3 time with no counter overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Starts a wait when high in idle; lowering it after completion releases the timer |
| delay_ms_i | input | CNT_W | Requested wait in milliseconds |
| done_o | output | 1 | Wait complete; held until en_i is seen low |

## Verification
The bench shrinks the clock-to-tick ratio to 10, so a request of N is due at done_o N*10+1 cycles after the edge that samples enable. A zero request is due after 1 cycle, and the flag drop is due one cycle after enable is sampled low. Inputs change one time unit after a rising edge, and every output is read on the falling edge. The monitor counts falling edges from the starting edge and compares the count at the first high done_o with the value the driver queued. The driver then checks the flag on the falling edges on either side of the edge that samples enable low.

// File: rtl/ms_delay_pkg.sv
package ms_delay_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_DONE = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/ms_delay_prescaler.sv
module ms_delay_prescaler #(
  parameter int unsigned DIV = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = run_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  p_presc_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_tick_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ms_delay_counter.sv
module ms_delay_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (clr_i)   count_o <= '0;
    else if (tick_i)  count_o <= count_o + 1'b1;
  end

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0));
  p_idle_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(count_o));
endmodule

// File: rtl/ms_delay_fsm.sv
module ms_delay_fsm
  import ms_delay_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] req_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             clr_o,
  output logic             run_o,
  output logic             finish_o
);
  tmr_state_e       state_q, state_d;
  logic [CNT_W-1:0] req_q;

  assign clr_o    = (state_q == ST_IDLE) & en_i;
  assign run_o    = (state_q == ST_HOLD);
  assign finish_o = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (en_i)             state_d = ST_HOLD;
      ST_HOLD: if (count_i == req_q) state_d = ST_DONE;
      ST_DONE: if (!en_i)            state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
    end else begin
      state_q <= state_d;
      if (clr_o) req_q <= req_i;  // capture request at start only
    end
  end

  p_req_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o)) |-> $stable(req_q));
  p_no_overshoot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (count_i <= req_q));
  p_zero_fast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o && req_i == '0) |=> ##1 finish_o);
  p_finish_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish_o && en_i) |=> finish_o);
  p_finish_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish_o && !en_i) |=> !finish_o);
  p_start_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> run_o);
endmodule

// File: rtl/ms_delay_timer.sv
module ms_delay_timer #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TICK_HZ = 1000,
  parameter int unsigned CNT_W   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] delay_ms_i,
  output logic             done_o
);
  localparam int unsigned DIV = CLK_HZ / TICK_HZ;

  logic             clr;
  logic             run;
  logic             tick;
  logic [CNT_W-1:0] ms_cnt;

  ms_delay_prescaler #(.DIV(DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .run_i  (run),
    .tick_o (tick)
  );

  ms_delay_counter #(.CNT_W(CNT_W)) u_ms_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (tick),
    .count_o (ms_cnt)
  );

  ms_delay_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .req_i    (delay_ms_i),
    .count_i  (ms_cnt),
    .clr_o    (clr),
    .run_o    (run),
    .finish_o (done_o)
  );

  p_tick_only_running_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> run);
endmodule

// File: tb/ms_delay_timer_tb.sv
module ms_delay_timer_tb_top;
  localparam int unsigned P     = 10;
  localparam int unsigned CNT_W = 12;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             en_i;
  logic [CNT_W-1:0] delay_ms_i;
  logic             done_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  ms_delay_timer #(.CLK_HZ(P * 1000), .TICK_HZ(1000), .CNT_W(CNT_W)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .delay_ms_i (delay_ms_i),
    .done_o     (done_o)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    armed  = 1'b0;
  int    cyc    = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: counts cycles from the edge that samples enable to first done_o
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!armed && en_i && !done_o) begin
        armed = 1'b1;
        cyc   = -1;
      end else if (armed) begin
        cyc++;
        if (done_o) begin
          armed = 1'b0;
          if (exp_q.size() == 0) check(1'b0, "R3 unexpected done", cyc, -1);
          else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(cyc == e, t, cyc, e);
          end
        end
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk_i); while (!done_o);
  endtask

  task automatic start(input int n, input string tag);
    exp_q.push_back(n * P + 1);
    tag_q.push_back(tag);
    @(posedge clk_i); #1;
    delay_ms_i = CNT_W'(n);
    en_i = 1'b1;
  endtask

  task automatic run(input int n, input string tag);
    start(n, tag);
    wait_done();
  endtask

  task automatic release_en();
    @(posedge clk_i); #1;
    en_i = 1'b0;
    @(negedge clk_i);
    check(done_o == 1'b1, "R6 before sampling edge", int'(done_o), 1);
    @(negedge clk_i);
    check(done_o == 1'b0, "R6 after sampling edge", int'(done_o), 0);
  endtask

  initial begin
    rst_ni = 1'b0;
    en_i = 1'b0;
    delay_ms_i = '0;
    repeat (3) @(negedge clk_i);
    check(done_o == 1'b0, "R2 in reset", int'(done_o), 0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    check(done_o == 1'b0, "R2 idle", int'(done_o), 0);

    run(3, "R3 n=3");
    repeat (25) @(negedge clk_i);
    check(done_o == 1'b1, "R5 held while enabled", int'(done_o), 1);
    release_en();

    run(0, "R4 zero request");
    release_en();

    run(1, "R1 n=1");
    release_en();
    run(2, "R1 n=2");
    release_en();

    // R7: request changes mid-count
    start(5, "R7 latched request");
    repeat (12) @(posedge clk_i);
    #1 delay_ms_i = 12'd1;
    repeat (9) @(posedge clk_i);
    #1 delay_ms_i = 12'd9;
    wait_done();
    release_en();

    // R8: after a long idle gap, then back to back
    repeat (37) @(posedge clk_i);
    run(2, "R8 after idle gap");
    release_en();
    run(4, "R8 back to back");
    release_en();

    // R9: enable dropped mid-count
    start(2, "R9 no abort");
    repeat (5) @(posedge clk_i);
    #1 en_i = 1'b0;
    wait_done();
    @(negedge clk_i);
    check(done_o == 1'b0, "R9 falls next cycle", int'(done_o), 0);

    run(4095, "R10 full width");
    release_en();

    repeat (5) @(negedge clk_i);
    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule